// File: doc/BRIEF.md
# Dual-Speed Serial Baud Rate Generator

This block derives the timing strobes for an asynchronous serial port from the system clock. A 12-bit divider value sets the length of one sample period. The divider is written as two bytes. The low byte has an address of its own. The upper four bits sit behind a second address, which is shared with a small control register. Bit 7 of the byte written to that shared address chooses which of the two registers takes the write.

A down-counter runs from the divider value to zero. When it reaches zero it raises a one-cycle sample strobe and reloads. A second counter groups sample strobes into bit strobes: 16 samples make one bit normally, and 8 make one bit when double speed is selected. Double speed applies only while the control register selects asynchronous mode.

Writing the low byte reloads the counter at once. Writing the upper bits alone leaves the current period running. The transmitter and receiver of the port use the two strobes as their timing.

Top module: `baud_rate_gen`

## Requirements
- R1: After reset the divider is 0. A sample strobe is then high on every clock cycle. Reading the low byte returns 8'h00, reading the upper divider bits returns 8'h00, and reading the control register returns 8'h80.
- R2: With divider value D, consecutive sample strobes are exactly D+1 clock cycles apart.
- R3: A write to the low-byte address (address 0) reloads the counter with {upper bits, written byte} on the same clock edge. The first sample strobe after that edge is high in the cycle that follows the (D+1)-th later edge. A reload also cancels any strobe that was pending.
- R4: A write to the upper divider bits alone does not reload. The period in progress keeps its old length, and the full new value applies from the next reload at the end of that period.
- R5: At the shared address (address 1), wr_data[7]=0 writes wr_data[3:0] into divider bits 11:8. wr_data[7]=1 writes the control register: bit 6 selects synchronous mode and bit 1 selects double speed. Neither kind of write changes the other register.
- R6: Read data appears one clock after rd_addr and rd_ctrl are presented. Reading the upper divider bits returns 0 in bit 7 and 0 in the reserved bits 6:4, even if ones were written there. Reading the control register returns 1 in bit 7, the mode bit in bit 6, the speed bit in bit 1, and zeros elsewhere.
- R7: A bit strobe is issued on every 16th sample strobe in normal speed. It is always high in the same cycle as a sample strobe.
- R8: When double speed is set and synchronous mode is clear, a bit strobe is issued on every 8th sample strobe. When synchronous mode is set, the count stays at 16 even if double speed is set.
- R9: A low-byte reload restarts the sample count. The first bit strobe after a reload falls on the 16th sample strobe, or the 8th in double speed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = divider low byte, 1 = shared address |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 1 | Read address, same encoding as wr_addr |
| rd_ctrl | input | 1 | At address 1: 1 reads the control register, 0 reads the divider upper bits |
| rd_data | output | 8 | Registered read data |
| sample_tick | output | 1 | One-cycle strobe per sample period |
| bit_tick | output | 1 | One-cycle strobe per bit period |

## Verification
Each result is due in a fixed cycle:
- A low-byte write edge is followed by the first sample strobe exactly D+2 falling edges later.
- Later strobes come every D+1 cycles.
- Read data is due at the first falling edge after the sampling edge.
- A bit strobe is counted in sample strobes, not in cycles.

The bench drives inputs on falling edges and samples outputs on falling edges. It counts the falling edges since the write edge, or since the last strobe, and compares that count with the value worked out from D. When the speed is changed, the first bit period after the change is skipped, and only a complete bit period is measured.

// File: rtl/baud_rate_pkg.sv
package baud_rate_pkg;
  // Register addresses
  localparam logic ADDR_DIV_LO = 1'b0;
  localparam logic ADDR_SHARED = 1'b1;

  // Control register bit positions (byte written at the shared address)
  localparam int CTRL_SEL_BIT  = 7;
  localparam int CTRL_SYNC_BIT = 6;
  localparam int CTRL_DBL_BIT  = 1;

  typedef struct packed {
    logic sync_mode;
    logic dbl_speed;
  } ctrl_t;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_rate_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_addr,
  input  logic              rd_ctrl,
  output logic [BYTE_W-1:0] rd_data,
  output logic [DIV_W-1:0]  div_o,
  output logic [DIV_W-1:0]  load_val_o,
  output logic              reload_o,
  output ctrl_t             ctrl_o
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic [BYTE_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  ctrl_t             ctrl_q;
  logic              wr_lo, wr_hi, wr_ctl;

  // Shared-address decode: bit 7 of the written byte steers the write
  always_comb begin
    wr_lo  = wr_en && (wr_addr == ADDR_DIV_LO);
    wr_hi  = wr_en && (wr_addr == ADDR_SHARED) && !wr_data[CTRL_SEL_BIT];
    wr_ctl = wr_en && (wr_addr == ADDR_SHARED) &&  wr_data[CTRL_SEL_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_lo) lo_q <= wr_data;
      if (wr_hi) hi_q <= wr_data[HI_W-1:0];
      if (wr_ctl) begin
        ctrl_q.sync_mode <= wr_data[CTRL_SYNC_BIT];
        ctrl_q.dbl_speed <= wr_data[CTRL_DBL_BIT];
      end
    end
  end

  // A low-byte write loads the counter on the same edge
  assign reload_o   = wr_lo;
  assign load_val_o = {hi_q, wr_data};
  assign div_o      = {hi_q, lo_q};
  assign ctrl_o     = ctrl_q;

  // Registered readback
  logic [BYTE_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADDR_DIV_LO) begin
      rd_mux = lo_q;
    end else if (rd_ctrl) begin
      rd_mux[CTRL_SEL_BIT]  = 1'b1;
      rd_mux[CTRL_SYNC_BIT] = ctrl_q.sync_mode;
      rd_mux[CTRL_DBL_BIT]  = ctrl_q.dbl_speed;
    end else begin
      rd_mux[HI_W-1:0] = hi_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  assert_ctrl_rd_bit7_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == ADDR_SHARED && $past(rd_ctrl) && !$past(rst)) |-> rd_data[CTRL_SEL_BIT]);

  assert_hi_rd_rsvd_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == ADDR_SHARED && !$past(rd_ctrl) && !$past(rst))
      |-> (rd_data[BYTE_W-1:HI_W] == '0));

  assert_shared_wr_no_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_SHARED) |-> !reload_o);

  assert_ctl_wr_keeps_hi_R5: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> $stable(hi_q));
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] div,
  output logic             wrap_o,
  output logic             sample_tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign wrap_o = !reload && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q         <= '0;
      sample_tick_o <= 1'b0;
    end else if (reload) begin
      cnt_q         <= load_val;
      sample_tick_o <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q         <= div;
      sample_tick_o <= 1'b1;
    end else begin
      cnt_q         <= cnt_q - 1'b1;
      sample_tick_o <= 1'b0;
    end
  end

  assert_no_tick_midcount_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !reload) |=> !sample_tick_o);

  assert_reload_cancels_tick_R3: assert property (@(posedge clk) disable iff (rst)
    reload |=> !sample_tick_o);
endmodule

// File: rtl/baud_bitdiv.sv
module baud_bitdiv #(
  parameter int OS_NORM = 16,
  parameter int OS_FAST = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic wrap,
  input  logic fast,
  output logic bit_tick_o
);
  localparam int SC_W = $clog2(OS_NORM);
  localparam logic [SC_W-1:0] LAST_NORM = SC_W'(OS_NORM - 1);
  localparam logic [SC_W-1:0] LAST_FAST = SC_W'(OS_FAST - 1);

  logic [SC_W-1:0] scnt_q;
  logic [SC_W-1:0] last;

  assign last = fast ? LAST_FAST : LAST_NORM;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      scnt_q     <= '0;
      bit_tick_o <= 1'b0;
    end else if (wrap) begin
      if (scnt_q >= last) begin
        scnt_q     <= '0;
        bit_tick_o <= 1'b1;
      end else begin
        scnt_q     <= scnt_q + 1'b1;
        bit_tick_o <= 1'b0;
      end
    end else begin
      bit_tick_o <= 1'b0;
    end
  end

  assert_bit_needs_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> !bit_tick_o);

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (scnt_q == '0 && !bit_tick_o));
endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import baud_rate_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int BYTE_W  = 8,
  parameter int OS_NORM = 16,
  parameter int OS_FAST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_addr,
  input  logic              rd_ctrl,
  output logic [BYTE_W-1:0] rd_data,
  output logic              sample_tick,
  output logic              bit_tick
);
  logic [DIV_W-1:0] div, load_val;
  logic             reload, wrap, fast;
  ctrl_t            ctrl;

  baud_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_ctrl(rd_ctrl), .rd_data(rd_data),
    .div_o(div), .load_val_o(load_val), .reload_o(reload), .ctrl_o(ctrl)
  );

  // Double speed only counts in asynchronous mode
  assign fast = ctrl.dbl_speed && !ctrl.sync_mode;

  baud_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .reload(reload), .load_val(load_val), .div(div),
    .wrap_o(wrap), .sample_tick_o(sample_tick)
  );

  baud_bitdiv #(.OS_NORM(OS_NORM), .OS_FAST(OS_FAST)) u_bit (
    .clk(clk), .rst(rst), .restart(reload), .wrap(wrap), .fast(fast),
    .bit_tick_o(bit_tick)
  );

  assert_bit_with_sample_R7: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> sample_tick);
endmodule

// File: tb/sim_baud_rate_gen.sv
module sim_baud_rate_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_addr = 1'b0;
  logic       rd_ctrl = 1'b0;
  logic [7:0] rd_data;
  logic       sample_tick, bit_tick;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  baud_rate_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_ctrl(rd_ctrl), .rd_data(rd_data),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, input logic c, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a; rd_ctrl = c;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  // Count falling edges until sample_tick is seen, starting at n0
  task automatic wait_tick(input int n0, output int n);
    n = n0;
    while (!sample_tick && n < 6000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic gap(output int n);
    @(negedge clk);
    wait_tick(1, n);
  endtask

  // Sample strobes from one bit strobe to the next, inclusive
  task automatic bit_gap(input string req, output int s);
    int guard;
    guard = 0;
    while (!bit_tick && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    s = 0;
    do begin
      @(negedge clk);
      guard++;
      if (sample_tick) s++;
      if (bit_tick && !sample_tick) chk(1'b0, req, 0, 1);
    end while (!bit_tick && guard < 20000);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    int n;
    rd(1'b1, 1'b1, d); chk(d == 8'h80, "R1 ctrl readback", d, 8'h80);
    rd(1'b1, 1'b0, d); chk(d == 8'h00, "R1 hi readback", d, 8'h00);
    rd(1'b0, 1'b0, d); chk(d == 8'h00, "R1 lo readback", d, 8'h00);
    wait_tick(0, n);
    gap(n); chk(n == 1, "R1 tick every cycle", n, 1);
  endtask

  task automatic t_reload();
    int n;
    wr(1'b0, 8'd5);
    wait_tick(1, n); chk(n == 7, "R3 first tick after low write D=5", n, 7);
    gap(n); chk(n == 6, "R2 period D=5", n, 6);
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h03);
    wait_tick(1, n); chk(n == 261, "R3 first tick after low write D=0x103", n, 261);
    gap(n); chk(n == 260, "R2 period D=0x103", n, 260);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_high_only();
    int n;
    logic [7:0] d;
    wr(1'b0, 8'd9);
    wait_tick(1, n);
    wr(1'b1, 8'h71);
    wait_tick(2, n); chk(n == 10, "R4 running period keeps old length", n, 10);
    gap(n); chk(n == 266, "R4 new value after next reload", n, 266);
    rd(1'b1, 1'b0, d); chk(d == 8'h01, "R6 reserved hi bits read zero", d, 8'h01);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd1);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    int s;
    wr(1'b1, 8'h05);
    wr(1'b1, 8'hC2);
    rd(1'b1, 1'b1, d); chk(d == 8'hC2, "R6 ctrl readback", d, 8'hC2);
    rd(1'b1, 1'b0, d); chk(d == 8'h05, "R5 ctrl write keeps hi", d, 8'h05);
    wr(1'b1, 8'h00);
    rd(1'b1, 1'b1, d); chk(d == 8'hC2, "R5 hi write keeps ctrl", d, 8'hC2);
    wr(1'b0, 8'd1);
    bit_gap("R7", s);
    bit_gap("R8", s); chk(s == 16, "R8 sync mode ignores double speed", s, 16);
    wr(1'b1, 8'h82);
    bit_gap("R8", s);
    bit_gap("R8", s); chk(s == 8, "R8 double speed 8 samples/bit", s, 8);
    wr(1'b1, 8'h80);
    bit_gap("R7", s);
    bit_gap("R7", s); chk(s == 16, "R7 normal 16 samples/bit", s, 16);
  endtask

  task automatic restart_count(input logic [7:0] lo, output int s);
    int guard;
    wr(1'b0, lo);
    s = 0; guard = 0;
    forever begin
      if (sample_tick) s++;
      if (bit_tick || guard > 20000) break;
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic t_restart();
    int s;
    restart_count(8'd3, s); chk(s == 16, "R9 first bit after reload normal", s, 16);
    wr(1'b1, 8'h82);
    restart_count(8'd2, s); chk(s == 8, "R9 first bit after reload double", s, 8);
    wr(1'b1, 8'h80);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_reload();
    t_high_only();
    t_ctrl();
    t_restart();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule